// File: doc/BRIEF.md
# In-Order Retirement Tracker with Register Mapping

This block tracks instructions in flight inside an out-of-order core. Each instruction takes a slot in a circular buffer in program order when it is allocated. The slot records an optional memory write (address and size) and a per-slot progress status. Execution units report completion by slot index. Entries then leave the buffer strictly in order, up to a parameterised number per cycle. An entry that carries a memory write leaves only when the load/store queue has room, and at that moment it hands its address, size and slot index to that queue as a store.

Alongside the buffer sits a register mapping table. For each architectural register it records either "value is in the register file" or the slot of the newest instruction that will write it. Allocation points every valid destination register at the new slot. Retirement of a slot clears every mapping that still names it, so a later writer of the same register keeps its own mapping. A lookup port returns the mapping for one register, and a status port returns the status of one slot. Rename and wakeup logic elsewhere uses these two ports.

The pointer controller is a two-state machine. In state S_EMPTY both pointers are undefined (the "-1" condition). In state S_ACTIVE the head names the oldest live slot and the tail names the youngest. The transitions are T_FIRST_ALLOC (S_EMPTY to S_ACTIVE, both pointers set to slot 0), T_STEP (S_ACTIVE to S_ACTIVE, head advances by the retire count and tail advances on allocation), T_DRAIN (S_ACTIVE to S_EMPTY, when every live entry retires and nothing is allocated), and T_DRAIN_REFILL (S_ACTIVE to S_ACTIVE, when every live entry retires while a new one is allocated, so head and tail both move to the slot after the old tail).

Top module: `reorder_tracker`

## Requirements
- R1: After reset, `empty` is 1 and `full` is 0. Every slot reads status 7 (unused), and no register reads as mapped.
- R2: The first allocation from the empty state takes slot 0. While entries are live, `alloc_idx` is the slot after the youngest live slot, modulo the depth.
- R3: `full` is 1 exactly when all slots are live: the head is slot 0 and the tail is the last slot, or the tail is one slot behind the head. An allocation request while `full` is 1 is ignored.
- R4: Slot status is encoded as 0 issued, 1 dispatched, 2 executed, 3 retired and 7 unused. Allocation sets 0, a dispatch report sets 1, a completion report sets 2 and retirement sets 3.
- R5: A completion report for the head slot takes effect at the clock edge. A retirement decision in that same cycle uses the status from before the report.
- R6: Each cycle, from the head onward, the block retires consecutive live entries whose status is 2, up to the commit width. It stops at the first entry that does not qualify. `retire_cnt` gives the number retired.
- R7: An entry with a nonzero write address retires only when `lsq_space` is 1, and at most one such entry retires per cycle. When it retires, `st_valid` is 1 with its address, size and slot index.
- R8: When every live entry retires and nothing is allocated, the block returns to empty. When every live entry retires in the same cycle as an allocation, the new entry becomes the only live entry, in the slot after the old tail.
- R9: An allocation maps each destination register whose valid bit is set to the new slot. `map_q_hit` and `map_q_idx` report the mapping of `map_q_reg`.
- R10: Retiring a slot clears every register mapping that holds that slot. A mapping to a different slot is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_dst_vld | input | DST_N | Valid bit for each destination register |
| alloc_dst | input | DST_N x RGW | Destination register numbers |
| alloc_waddr | input | AW | Memory write address, 0 when there is no write |
| alloc_wsize | input | ZW | Memory write size |
| alloc_idx | output | IW | Slot the next allocation takes |
| full | output | 1 | All slots are live |
| empty | output | 1 | No live slot |
| disp_valid | input | 1 | Dispatch report |
| disp_idx | input | IW | Slot that was dispatched |
| cmpl_valid | input | 1 | Completion report |
| cmpl_idx | input | IW | Slot that completed |
| lsq_space | input | 1 | Load/store queue can take a store |
| st_valid | output | 1 | Store handed to the load/store queue |
| st_addr | output | AW | Store address |
| st_size | output | ZW | Store size |
| st_rob_idx | output | IW | Slot of the retiring store |
| retire_cnt | output | RW | Number of entries retiring this cycle |
| map_q_reg | input | RGW | Register to look up |
| map_q_hit | output | 1 | Register is mapped to a slot |
| map_q_idx | output | IW | Slot the register is mapped to |
| stat_q_idx | input | IW | Slot to read status from |
| stat_q_val | output | 3 | Status of that slot |

## Verification
A head or tail pointer that drifts shows up at once at the ports. `alloc_idx` and `full` are wrong in the same cycle, and `retire_cnt` or `st_rob_idx` is wrong within the few cycles it takes for the entries involved to complete. A status that is lost or overwritten shows through `stat_q_val` as soon as that slot is queried. It also shows as a stalled or premature retirement at the head. A mapping table that misses a clear, or clears too much, reads wrong on `map_q_hit` the cycle after the retirement. The bench runs a small configuration next to a cycle-level model and compares every output on every cycle.

// File: rtl/rt_pkg.sv
package rt_pkg;
    typedef enum logic [2:0] {
        ST_ISSUED = 3'd0,
        ST_DISP   = 3'd1,
        ST_EXEC   = 3'd2,
        ST_DONE   = 3'd3,
        ST_FREE   = 3'd7
    } slot_st_e;

    typedef enum logic {
        S_EMPTY  = 1'b0,
        S_ACTIVE = 1'b1
    } ptr_state_e;
endpackage

// File: rtl/rt_ptr_fsm.sv
module rt_ptr_fsm
    import rt_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int RW = $clog2(CW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_req,
    input  logic [RW-1:0]   ret_n,
    output logic [IW-1:0]   head,
    output logic [CNTW-1:0] occ,
    output logic            empty,
    output logic            full,
    output logic [IW-1:0]   alloc_idx,
    output logic            alloc_fire
);
    ptr_state_e state_q, state_d;
    logic [IW-1:0] head_q, head_d, tail_q, tail_d;
    logic drain;

    function automatic logic [IW-1:0] step1(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [IW-1:0] stepn(input logic [IW-1:0] p, input logic [RW-1:0] n);
        logic [IW+RW:0] s;
        s = (IW+RW+1)'(p) + (IW+RW+1)'(n);
        if (s >= (IW+RW+1)'(DEPTH)) s = s - (IW+RW+1)'(DEPTH);
        return s[IW-1:0];
    endfunction

    // Outputs derived from the pointer state
    always_comb begin
        empty = (state_q == S_EMPTY);
        occ   = '0;
        full  = 1'b0;
        if (state_q == S_ACTIVE) begin
            if (tail_q >= head_q)
                occ = CNTW'(tail_q) - CNTW'(head_q) + CNTW'(1);
            else
                occ = CNTW'(DEPTH) + CNTW'(tail_q) - CNTW'(head_q) + CNTW'(1);
            full = ((head_q == '0) && (tail_q == IW'(DEPTH - 1))) || (step1(tail_q) == head_q);
        end
        alloc_fire = alloc_req && !full;
        alloc_idx  = empty ? '0 : step1(tail_q);
        head       = head_q;
        drain      = (state_q == S_ACTIVE) && (CNTW'(ret_n) == occ);
    end

    // Transitions: T_FIRST_ALLOC, T_STEP, T_DRAIN, T_DRAIN_REFILL
    always_comb begin
        state_d = state_q;
        head_d  = head_q;
        tail_d  = tail_q;
        unique case (state_q)
            S_EMPTY: begin
                if (alloc_fire) begin
                    state_d = S_ACTIVE;
                    head_d  = '0;
                    tail_d  = '0;
                end
            end
            S_ACTIVE: begin
                if (drain && !alloc_fire) begin
                    state_d = S_EMPTY;
                end else if (drain) begin
                    head_d = step1(tail_q);
                    tail_d = step1(tail_q);
                end else begin
                    head_d = stepn(head_q, ret_n);
                    if (alloc_fire) tail_d = step1(tail_q);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            state_q <= state_d;
            head_q  <= head_d;
            tail_q  <= tail_d;
        end
    end

    p_first_slot_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMPTY && alloc_fire) |=> (state_q == S_ACTIVE && head_q == '0 && tail_q == '0));
    p_full_blocks_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_req) |=> $stable(tail_q));
    p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNTW'(DEPTH));
    p_drain_to_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !alloc_fire) |=> empty);
endmodule

// File: rtl/rt_retire_pick.sv
module rt_retire_pick
    import rt_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW = 8,
    parameter int AW = 32,
    parameter int ZW = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int RW = $clog2(CW + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IW-1:0]            head,
    input  logic [CNTW-1:0]          occ,
    input  logic [DEPTH-1:0][2:0]    status,
    input  logic [DEPTH-1:0][AW-1:0] waddr,
    input  logic [DEPTH-1:0][ZW-1:0] wsize,
    input  logic                     lsq_space,
    output logic [RW-1:0]            ret_n,
    output logic [DEPTH-1:0]         ret_mask,
    output logic                     sq_valid,
    output logic [AW-1:0]            sq_addr,
    output logic [ZW-1:0]            sq_size,
    output logic [IW-1:0]            sq_idx
);
    function automatic logic [IW-1:0] slot_at(input logic [IW-1:0] p, input int k);
        logic [IW+RW:0] s;
        s = (IW+RW+1)'(p) + (IW+RW+1)'(k);
        if (s >= (IW+RW+1)'(DEPTH)) s = s - (IW+RW+1)'(DEPTH);
        return s[IW-1:0];
    endfunction

    always_comb begin
        logic go;
        logic [IW-1:0] idx;
        go       = 1'b1;
        ret_n    = '0;
        ret_mask = '0;
        sq_valid = 1'b0;
        sq_addr  = '0;
        sq_size  = '0;
        sq_idx   = '0;
        for (int k = 0; k < CW; k++) begin
            idx = slot_at(head, k);
            if (go && (CNTW'(k) < occ) && (status[idx] == ST_EXEC)) begin
                if (waddr[idx] != '0) begin
                    if (lsq_space && !sq_valid) begin
                        sq_valid = 1'b1;
                        sq_addr  = waddr[idx];
                        sq_size  = wsize[idx];
                        sq_idx   = idx;
                        ret_mask[idx] = 1'b1;
                        ret_n = ret_n + 1'b1;
                    end else begin
                        go = 1'b0;
                    end
                end else begin
                    ret_mask[idx] = 1'b1;
                    ret_n = ret_n + 1'b1;
                end
            end else begin
                go = 1'b0;
            end
        end
    end

    p_store_needs_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> lsq_space);
    p_retire_within_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        CNTW'(ret_n) <= occ);
    p_mask_matches_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ret_mask) == int'(ret_n));
endmodule

// File: rtl/rt_alias_map.sv
module rt_alias_map #(
    parameter int NREG = 32,
    parameter int DST_N = 4,
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH),
    localparam int RGW = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_en,
    input  logic [DST_N-1:0]          set_vld,
    input  logic [DST_N-1:0][RGW-1:0] set_reg,
    input  logic [IW-1:0]             set_idx,
    input  logic [DEPTH-1:0]          clr_mask,
    input  logic [RGW-1:0]            q_reg,
    output logic                      q_hit,
    output logic [IW-1:0]             q_idx
);
    logic [NREG-1:0]         map_v;
    logic [NREG-1:0][IW-1:0] map_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_v <= '0;
            map_i <= '0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (map_v[r] && clr_mask[map_i[r]]) map_v[r] <= 1'b0;
            end
            for (int j = 0; j < DST_N; j++) begin
                if (set_en && set_vld[j]) begin
                    map_v[set_reg[j]] <= 1'b1;
                    map_i[set_reg[j]] <= set_idx;
                end
            end
        end
    end

    assign q_hit = map_v[q_reg];
    assign q_idx = map_i[q_reg];

    p_alloc_maps_dst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && set_vld[0]) |=> (map_v[$past(set_reg[0])] && map_i[$past(set_reg[0])] == $past(set_idx)));
    p_retire_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (map_v[q_reg] && clr_mask[map_i[q_reg]] && !set_en) |=> !map_v[$past(q_reg)]);
endmodule

// File: rtl/reorder_tracker.sv
module reorder_tracker
    import rt_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NREG = 32,
    parameter int CW = 8,
    parameter int DST_N = 4,
    parameter int AW = 32,
    parameter int ZW = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int RGW = $clog2(NREG),
    localparam int RW = $clog2(CW + 1),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_valid,
    input  logic [DST_N-1:0]          alloc_dst_vld,
    input  logic [DST_N-1:0][RGW-1:0] alloc_dst,
    input  logic [AW-1:0]             alloc_waddr,
    input  logic [ZW-1:0]             alloc_wsize,
    output logic [IW-1:0]             alloc_idx,
    output logic                      full,
    output logic                      empty,
    input  logic                      disp_valid,
    input  logic [IW-1:0]             disp_idx,
    input  logic                      cmpl_valid,
    input  logic [IW-1:0]             cmpl_idx,
    input  logic                      lsq_space,
    output logic                      st_valid,
    output logic [AW-1:0]             st_addr,
    output logic [ZW-1:0]             st_size,
    output logic [IW-1:0]             st_rob_idx,
    output logic [RW-1:0]             retire_cnt,
    input  logic [RGW-1:0]            map_q_reg,
    output logic                      map_q_hit,
    output logic [IW-1:0]             map_q_idx,
    input  logic [IW-1:0]             stat_q_idx,
    output logic [2:0]                stat_q_val
);
    logic [DEPTH-1:0][2:0]    status_q;
    logic [DEPTH-1:0][AW-1:0] waddr_q;
    logic [DEPTH-1:0][ZW-1:0] wsize_q;
    logic [IW-1:0]            head;
    logic [CNTW-1:0]          occ;
    logic                     alloc_fire;
    logic [DEPTH-1:0]         ret_mask;

    rt_ptr_fsm #(.DEPTH(DEPTH), .CW(CW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_valid), .ret_n(retire_cnt),
        .head(head), .occ(occ), .empty(empty), .full(full),
        .alloc_idx(alloc_idx), .alloc_fire(alloc_fire)
    );

    rt_retire_pick #(.DEPTH(DEPTH), .CW(CW), .AW(AW), .ZW(ZW)) u_pick (
        .clk(clk), .rst_n(rst_n), .head(head), .occ(occ), .status(status_q),
        .waddr(waddr_q), .wsize(wsize_q), .lsq_space(lsq_space),
        .ret_n(retire_cnt), .ret_mask(ret_mask), .sq_valid(st_valid),
        .sq_addr(st_addr), .sq_size(st_size), .sq_idx(st_rob_idx)
    );

    rt_alias_map #(.NREG(NREG), .DST_N(DST_N), .DEPTH(DEPTH)) u_map (
        .clk(clk), .rst_n(rst_n), .set_en(alloc_fire), .set_vld(alloc_dst_vld),
        .set_reg(alloc_dst), .set_idx(alloc_idx), .clr_mask(ret_mask),
        .q_reg(map_q_reg), .q_hit(map_q_hit), .q_idx(map_q_idx)
    );

    // Slot status: later writes take priority (dispatch < completion < retire < allocate)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) status_q[i] <= ST_FREE;
            waddr_q <= '0;
            wsize_q <= '0;
        end else begin
            if (disp_valid) status_q[disp_idx] <= ST_DISP;
            if (cmpl_valid) status_q[cmpl_idx] <= ST_EXEC;
            for (int i = 0; i < DEPTH; i++) begin
                if (ret_mask[i]) status_q[i] <= ST_DONE;
            end
            if (alloc_fire) begin
                status_q[alloc_idx] <= ST_ISSUED;
                waddr_q[alloc_idx]  <= alloc_waddr;
                wsize_q[alloc_idx]  <= alloc_wsize;
            end
        end
    end

    assign stat_q_val = status_q[stat_q_idx];

    p_cmpl_marks_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && !ret_mask[cmpl_idx]) |=> status_q[$past(cmpl_idx)] == ST_EXEC);
    p_alloc_marks_issued_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> status_q[$past(alloc_idx)] == ST_ISSUED);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot_chk
        p_retire_needs_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ret_mask[g] |-> status_q[g] == ST_EXEC);
        p_retire_marks_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ret_mask[g] |=> status_q[g] == ST_DONE);
    end
endmodule

// File: tb/reorder_tracker_tb.sv
module reorder_tracker_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int D = 4, NR = 8, CWB = 2, DN = 2, AW = 8, ZW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0;
    logic [DN-1:0] alloc_dst_vld = '0;
    logic [DN-1:0][2:0] alloc_dst = '0;
    logic [AW-1:0] alloc_waddr = '0;
    logic [ZW-1:0] alloc_wsize = '0;
    logic [1:0] alloc_idx;
    logic full, empty;
    logic disp_valid = 0, cmpl_valid = 0, lsq_space = 1;
    logic [1:0] disp_idx = '0, cmpl_idx = '0, stat_q_idx = '0;
    logic st_valid;
    logic [AW-1:0] st_addr;
    logic [ZW-1:0] st_size;
    logic [1:0] st_rob_idx, retire_cnt, map_q_idx;
    logic [2:0] map_q_reg = '0, stat_q_val;
    logic map_q_hit;

    reorder_tracker #(.DEPTH(D), .NREG(NR), .CW(CWB), .DST_N(DN), .AW(AW), .ZW(ZW)) u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_dst_vld(alloc_dst_vld),
        .alloc_dst(alloc_dst), .alloc_waddr(alloc_waddr), .alloc_wsize(alloc_wsize),
        .alloc_idx(alloc_idx), .full(full), .empty(empty), .disp_valid(disp_valid),
        .disp_idx(disp_idx), .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
        .lsq_space(lsq_space), .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .st_rob_idx(st_rob_idx), .retire_cnt(retire_cnt), .map_q_reg(map_q_reg),
        .map_q_hit(map_q_hit), .map_q_idx(map_q_idx), .stat_q_idx(stat_q_idx),
        .stat_q_val(stat_q_val)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Reference model state
    int m_st[D], m_addr[D], m_size[D];
    bit m_empty = 1;
    int m_head = 0, m_tail = 0;
    bit rv[NR];
    int ri[NR];

    task automatic chk(input bit ok, input string req, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, tag, what, act, exp);
        end
    endtask

    task automatic idle_stim();
        alloc_valid = 0; disp_valid = 0; cmpl_valid = 0; lsq_space = 1;
    endtask

    // One clock: check outputs against the model, then advance the model
    task automatic cycle(input string tag);
        int occ, e_aidx, n, sidx;
        bit e_full, sv, fire;
        bit retd[D];
        #1;
        occ = m_empty ? 0 : ((m_tail - m_head + D) % D) + 1;
        e_full = (occ == D);
        e_aidx = m_empty ? 0 : (m_tail + 1) % D;
        n = 0; sv = 0; sidx = 0;
        for (int i = 0; i < D; i++) retd[i] = 0;
        for (int k = 0; k < CWB; k++) begin
            int idx;
            if (k >= occ) break;
            idx = (m_head + k) % D;
            if (m_st[idx] != 2) break;
            if (m_addr[idx] != 0) begin
                if (!lsq_space || sv) break;
                sv = 1; sidx = idx;
            end
            retd[idx] = 1;
            n++;
        end
        chk(empty == m_empty, "R8", tag, "empty", empty, m_empty);
        chk(full == e_full, "R3", tag, "full", full, e_full);
        chk(int'(alloc_idx) == e_aidx, "R2", tag, "alloc_idx", alloc_idx, e_aidx);
        chk(int'(retire_cnt) == n, "R6", tag, "retire_cnt", retire_cnt, n);
        chk(st_valid == sv, "R7", tag, "st_valid", st_valid, sv);
        if (sv) begin
            chk(int'(st_rob_idx) == sidx, "R7", tag, "st_rob_idx", st_rob_idx, sidx);
            chk(int'(st_addr) == m_addr[sidx], "R7", tag, "st_addr", st_addr, m_addr[sidx]);
            chk(int'(st_size) == m_size[sidx], "R7", tag, "st_size", st_size, m_size[sidx]);
        end
        chk(map_q_hit == rv[map_q_reg], "R9", tag, "map_q_hit", map_q_hit, rv[map_q_reg]);
        if (rv[map_q_reg])
            chk(int'(map_q_idx) == ri[map_q_reg], "R9", tag, "map_q_idx", map_q_idx, ri[map_q_reg]);
        chk(int'(stat_q_val) == m_st[stat_q_idx], "R4", tag, "stat_q_val", stat_q_val, m_st[stat_q_idx]);
        fire = alloc_valid && !e_full;
        @(posedge clk);
        #1;
        if (disp_valid) m_st[disp_idx] = 1;
        if (cmpl_valid) m_st[cmpl_idx] = 2;
        for (int i = 0; i < D; i++) if (retd[i]) m_st[i] = 3;
        for (int r = 0; r < NR; r++) if (rv[r] && retd[ri[r]]) rv[r] = 0;
        if (fire) begin
            m_st[e_aidx] = 0;
            m_addr[e_aidx] = alloc_waddr;
            m_size[e_aidx] = alloc_wsize;
            for (int j = 0; j < DN; j++)
                if (alloc_dst_vld[j]) begin rv[alloc_dst[j]] = 1; ri[alloc_dst[j]] = e_aidx; end
        end
        if (m_empty) begin
            if (fire) begin m_empty = 0; m_head = 0; m_tail = 0; end
        end else if (n == occ) begin
            if (fire) begin m_tail = (m_tail + 1) % D; m_head = m_tail; end
            else m_empty = 1;
        end else begin
            m_head = (m_head + n) % D;
            if (fire) m_tail = (m_tail + 1) % D;
        end
        @(negedge clk);
    endtask

    task automatic do_alloc(input int r, input int a, input string tag);
        idle_stim();
        alloc_valid = 1; alloc_dst_vld = 2'b01; alloc_dst[0] = 3'(r);
        alloc_waddr = 8'(a); alloc_wsize = 2'(r);
        cycle(tag);
    endtask

    task automatic do_cmpl(input int s, input bit space, input string tag);
        idle_stim();
        cmpl_valid = 1; cmpl_idx = 2'(s); lsq_space = space;
        cycle(tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #500us;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < D; i++) begin m_st[i] = 7; m_addr[i] = 0; m_size[i] = 0; end
        for (int r = 0; r < NR; r++) begin rv[r] = 0; ri[r] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state seen at the ports
        #1;
        chk(empty == 1'b1, "R1", "reset", "empty", empty, 1);
        chk(full == 1'b0, "R1", "reset", "full", full, 0);
        for (int s = 0; s < D; s++) begin
            stat_q_idx = 2'(s); #1;
            chk(stat_q_val == 3'd7, "R1", "reset", "status", stat_q_val, 7);
        end
        for (int r = 0; r < NR; r++) begin
            map_q_reg = 3'(r); #1;
            chk(map_q_hit == 1'b0, "R1", "reset", "mapped", map_q_hit, 0);
        end
        @(negedge clk);

        // R2: fill in order; slots 2 and 3 carry stores
        map_q_reg = 3'd0; stat_q_idx = 2'd0;
        do_alloc(0, 0, "R2");
        map_q_reg = 3'd0;
        do_alloc(1, 0, "R2");
        do_alloc(2, 8'h42, "R2");
        map_q_reg = 3'd2;
        do_alloc(3, 8'h43, "R2");
        // R3: request while full is ignored
        do_alloc(5, 0, "R3");
        map_q_reg = 3'd5;
        idle_stim(); cycle("R3");

        // R6: head not executed, nothing retires
        stat_q_idx = 2'd1;
        do_cmpl(1, 1, "R6");
        // R5: completion of the head in the same cycle as the retire decision
        stat_q_idx = 2'd0;
        do_cmpl(0, 1, "R5");
        map_q_reg = 3'd0;
        idle_stim(); cycle("R6");
        // R10: mapping of register 0 cleared after slot 0 retires
        idle_stim(); cycle("R10");

        // R7: stores wait for space, one per cycle
        do_cmpl(2, 0, "R7");
        do_cmpl(3, 0, "R7");
        idle_stim(); lsq_space = 1; stat_q_idx = 2'd2; cycle("R7");
        idle_stim(); stat_q_idx = 2'd3; cycle("R7");
        idle_stim(); cycle("R8");

        // R8: drain and allocate in the same cycle
        do_alloc(4, 0, "R8");
        do_cmpl(0, 1, "R8");
        map_q_reg = 3'd6;
        do_alloc(6, 0, "R8");
        idle_stim(); cycle("R8");

        // Near-exhaustive random sweep against the model
        for (int t = 0; t < 4000; t++) begin
            int d, c;
            alloc_valid = ($urandom % 4) != 0;
            alloc_dst_vld = 2'($urandom);
            alloc_dst[0] = 3'($urandom % NR);
            alloc_dst[1] = 3'($urandom % NR);
            alloc_waddr = ($urandom % 2) ? 8'd0 : 8'(($urandom % 255) + 1);
            alloc_wsize = 2'($urandom);
            d = $urandom % D;
            disp_idx = 2'(d);
            disp_valid = (m_st[d] == 0) && ($urandom % 2);
            c = $urandom % D;
            cmpl_idx = 2'(c);
            cmpl_valid = (m_st[c] == 0 || m_st[c] == 1) && !(disp_valid && c == d) && ($urandom % 2);
            lsq_space = ($urandom % 4) != 0;
            map_q_reg = 3'($urandom % NR);
            stat_q_idx = 2'($urandom % D);
            cycle("sweep");
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule